// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block sits on the host side of a serially programmed frequency synthesizer and brings it up after power is applied. One start request captures three 24-bit configuration words from its input ports. It then shifts them out over a three-wire link made of a serial clock, a data line and a latch-enable line. The words go out in a fixed order: reference divider, then control, then feedback divider. After each word the latch-enable line pulses high, which commits that word inside the target.

The block also drives the target's chip-enable line. Once the third word is committed, it watches the target's lock-detect output. It reports `done` when lock has been held for a programmable number of consecutive system-clock samples. It reports `timed_out` instead if a programmable cycle limit expires first. The serial clock is produced by dividing the system clock with a parameter, and an elaboration-time check keeps that clock at or below 20 MHz.

Top module: `synth_prog_seq`

## Requirements
- R1: After a start request, exactly three words are shifted out and committed, in this order: `word_ref`, then `word_ctl`, then `word_fb`. Each word is 24 bits long and goes out most significant bit first. The values used are the ones present on the ports in the cycle the start request is accepted.
- R2: `ser_clk` idles low. `ser_data` changes only while `ser_clk` is low, so it is stable across every rising edge, where the target captures it.
- R3: `ser_le` stays low while a word is being shifted. It rises only after the 24th rising edge of `ser_clk`, stays high for one full serial-clock period, and then stays low for at least one full period before the next word's first rising edge. `ser_clk` is never high while `ser_le` is high.
- R4: Every high and low phase of `ser_clk` lasts at least `DIV_HALF` system clocks, and each high phase lasts exactly `DIV_HALF`. The resulting rate `CLK_HZ/(2*DIV_HALF)` must not exceed 20 MHz, and this is checked at elaboration.
- R5: `chip_en` is low after reset. It goes high when the first start request is accepted and stays high from then on.
- R6: After the third commit, `done` rises once `lock_det` has been sampled high for `lock_need` consecutive system clocks. A value of 0 is treated as 1. The latency from the third falling edge of `ser_le` is at least `lock_need` cycles.
- R7: `timed_out` rises instead of `done` when `lock_limit` system clocks pass in the lock wait without enough consecutive lock samples. A run of high samples shorter than `lock_need` never produces `done`.
- R8: `busy` is high from the accepted start until `done` or `timed_out` rises. A start request while `busy` is high is ignored: the order and content of the words and the commit count are unchanged. `done` and `timed_out` are never high together, and they hold until the next accepted start.
- R9: During and right after reset, `ser_clk`, `ser_data`, `ser_le`, `chip_en`, `busy`, `done` and `timed_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only while idle |
| word_ref | input | 24 | Reference-divider word, sent first |
| word_ctl | input | 24 | Control word, sent second |
| word_fb | input | 24 | Feedback-divider word, sent third |
| lock_need | input | NEED_W | Consecutive lock samples required |
| lock_limit | input | TMO_W | Lock-wait limit in system clocks |
| lock_det | input | 1 | Lock-detect level from the target (asynchronous) |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch enable, commit pulse after each word |
| chip_en | output | 1 | Target power-up control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Lock confirmed |
| timed_out | output | 1 | Lock wait expired |

## Verification
The hardest situation to reach from the ports is a lock-detect signal that goes high repeatedly but never stays high long enough. Only then does the consecutive-sample counter have to reset, rather than simply run to its limit. The bench drives a repeating two-high, one-low pattern on `lock_det`. With a requirement of four samples, that pattern must end in a timeout; with a requirement of two, it must end in lock. A second hard case is a start request arriving mid-transfer with different words on the inputs. The bench injects one during the first word and checks that the three captured words still match the originals.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W    = 24;
  localparam int NUM_WORDS = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_SEND, SQ_WAIT} seq_state_t;
  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_LATCH} sh_state_t;
endpackage

// File: rtl/sclk_pacer.sv
module sclk_pacer #(
  parameter int DIV_HALF = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic half_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt       <= '0;
      half_tick <= 1'b0;
    end else if (cnt == CW'(DIV_HALF - 1)) begin
      cnt       <= '0;
      half_tick <= 1'b1;
    end else begin
      cnt       <= cnt + 1'b1;
      half_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              half_tick,
  output logic              sclk,
  output logic              sdata,
  output logic              le,
  output logic              word_done
);
  localparam int BW = $clog2(WORD_W);

  sh_state_t         st;
  logic [WORD_W-1:0] sreg;
  logic [BW-1:0]     bits;
  logic [1:0]        hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SH_IDLE;
      sreg      <= '0;
      bits      <= '0;
      hcnt      <= '0;
      sclk      <= 1'b0;
      sdata     <= 1'b0;
      le        <= 1'b0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (load) begin
            sreg  <= word;
            sdata <= word[WORD_W-1];
            bits  <= '0;
            sclk  <= 1'b0;
            st    <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (half_tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bits == BW'(WORD_W - 1)) begin
                hcnt <= '0;
                st   <= SH_LATCH;
              end else begin
                bits  <= bits + 1'b1;
                sreg  <= {sreg[WORD_W-2:0], 1'b0};
                sdata <= sreg[WORD_W-2];
              end
            end
          end
        end
        SH_LATCH: begin
          if (half_tick) begin
            hcnt <= hcnt + 1'b1;
            if (hcnt == 2'd0) le <= 1'b1;
            if (hcnt == 2'd2) le <= 1'b0;
            if (hcnt == 2'd3) begin
              word_done <= 1'b1;
              sdata     <= 1'b0;
              st        <= SH_IDLE;
            end
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
  parameter int NEED_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [NEED_W-1:0] need,
  input  logic [TMO_W-1:0]  limit,
  input  logic              lock_in,
  output logic              locked,
  output logic              expired
);
  logic [1:0]        sync;
  logic              armed;
  logic [NEED_W-1:0] run;
  logic [TMO_W-1:0]  tcnt;
  logic [NEED_W:0]   run_next;
  logic [TMO_W:0]    tcnt_next;

  assign run_next  = {1'b0, run} + (NEED_W+1)'(1);
  assign tcnt_next = {1'b0, tcnt} + (TMO_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= '0;
      armed   <= 1'b0;
      run     <= '0;
      tcnt    <= '0;
      locked  <= 1'b0;
      expired <= 1'b0;
    end else begin
      sync    <= {sync[0], lock_in};
      locked  <= 1'b0;
      expired <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        run   <= '0;
        tcnt  <= '0;
      end else if (armed) begin
        tcnt <= tcnt_next[TMO_W-1:0];
        run  <= sync[1] ? run_next[NEED_W-1:0] : '0;
        if (sync[1] && (run_next >= {1'b0, need})) begin
          locked <= 1'b1;
          armed  <= 1'b0;
        end else if (tcnt_next >= {1'b0, limit}) begin
          expired <= 1'b1;
          armed   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int CLK_HZ   = 200_000_000,
  parameter int DIV_HALF = 5,
  parameter int NEED_W   = 8,
  parameter int TMO_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word_ref,
  input  logic [WORD_W-1:0] word_ctl,
  input  logic [WORD_W-1:0] word_fb,
  input  logic [NEED_W-1:0] lock_need,
  input  logic [TMO_W-1:0]  lock_limit,
  input  logic              lock_det,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le,
  output logic              chip_en,
  output logic              busy,
  output logic              done,
  output logic              timed_out
);
  localparam int IW = $clog2(NUM_WORDS);

  seq_state_t        st;
  logic [WORD_W-1:0] wbuf [NUM_WORDS];
  logic [IW-1:0]     idx;
  logic              ld;
  logic              arm;
  logic              tick;
  logic              wdone;
  logic              mon_locked;
  logic              mon_expired;

  sclk_pacer #(.DIV_HALF(DIV_HALF)) u_pacer (
    .clk(clk), .rst(rst), .clr(ld), .half_tick(tick)
  );

  word_serializer u_ser (
    .clk(clk), .rst(rst), .load(ld), .word(wbuf[idx]), .half_tick(tick),
    .sclk(ser_clk), .sdata(ser_data), .le(ser_le), .word_done(wdone)
  );

  lock_watch #(.NEED_W(NEED_W), .TMO_W(TMO_W)) u_lock (
    .clk(clk), .rst(rst), .arm(arm), .need(lock_need), .limit(lock_limit),
    .lock_in(lock_det), .locked(mon_locked), .expired(mon_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      idx       <= '0;
      ld        <= 1'b0;
      arm       <= 1'b0;
      chip_en   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      for (int i = 0; i < NUM_WORDS; i++) wbuf[i] <= '0;
    end else begin
      ld  <= 1'b0;
      arm <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            wbuf[0]   <= word_ref;
            wbuf[1]   <= word_ctl;
            wbuf[2]   <= word_fb;
            idx       <= '0;
            chip_en   <= 1'b1;
            busy      <= 1'b1;
            done      <= 1'b0;
            timed_out <= 1'b0;
            st        <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          ld <= 1'b1;
          st <= SQ_SEND;
        end
        SQ_SEND: begin
          if (wdone) begin
            if (idx == IW'(NUM_WORDS - 1)) begin
              arm <= 1'b1;
              st  <= SQ_WAIT;
            end else begin
              idx <= idx + 1'b1;
              st  <= SQ_LOAD;
            end
          end
        end
        SQ_WAIT: begin
          if (mon_locked) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= SQ_IDLE;
          end else if (mon_expired) begin
            timed_out <= 1'b1;
            busy      <= 1'b0;
            st        <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/synth_prog_seq_checker.sv
module synth_prog_seq_checker #(
  parameter int CLK_HZ   = 200_000_000,
  parameter int DIV_HALF = 5
) (
  input logic clk,
  input logic rst,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_le,
  input logic chip_en,
  input logic busy,
  input logic done,
  input logic timed_out
);
  logic        prev_clk;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk <= 1'b0;
      run      <= '0;
    end else begin
      prev_clk <= ser_clk;
      if (ser_clk != prev_clk) run <= '0;
      else if (run != 16'hFFFF) run <= run + 1'b1;
    end
  end

  initial begin
    assert_sclk_rate_R4: assert (CLK_HZ / (2 * DIV_HALF) <= 20_000_000)
      else $error("serial clock above 20 MHz");
  end

  assert_sclk_half_period_R4: assert property (@(posedge clk) disable iff (rst)
    (ser_clk != prev_clk) |-> (run >= 16'(DIV_HALF - 1)));

  assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  assert_le_no_clk_R3: assert property (@(posedge clk) disable iff (rst)
    !(ser_le && ser_clk));

  assert_chip_en_busy_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> chip_en);

  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || timed_out));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timed_out}));

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind synth_prog_seq synth_prog_seq_checker #(.CLK_HZ(CLK_HZ), .DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
  .chip_en(chip_en), .busy(busy), .done(done), .timed_out(timed_out)
);

// File: tb/test_synth_prog_seq.sv
`timescale 1ns/1ps
module test_synth_prog_seq;
  localparam int DIV = 5;
  localparam int NW  = 8;
  localparam int TW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [23:0] w_ref = '0, w_ctl = '0, w_fb = '0;
  logic [NW-1:0] need = '0;
  logic [TW-1:0] lim = '0;
  logic lock_det = 1'b0;
  logic ser_clk, ser_data, ser_le, chip_en, busy, done, timed_out;

  always #2.5 clk = ~clk;

  synth_prog_seq #(.CLK_HZ(200_000_000), .DIV_HALF(DIV), .NEED_W(NW), .TMO_W(TW)) i_synth_prog_seq (
    .clk(clk), .rst(rst), .start(start), .word_ref(w_ref), .word_ctl(w_ctl), .word_fb(w_fb),
    .lock_need(need), .lock_limit(lim), .lock_det(lock_det),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le), .chip_en(chip_en),
    .busy(busy), .done(done), .timed_out(timed_out)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // serial receiver model: capture on rising serial clock, commit on LE rise
  logic [23:0] rx_sh;
  int rx_bits = 0;
  int le_cnt = 0;
  int bad_len = 0;
  logic [23:0] rx [4];
  always @(posedge ser_clk) begin
    rx_sh = {rx_sh[22:0], ser_data};
    rx_bits++;
  end
  always @(posedge ser_le) begin
    if (rx_bits != 24) bad_len++;
    if (le_cnt < 4) rx[le_cnt] = rx_sh;
    le_cnt++;
    rx_bits = 0;
  end

  // timing monitor sampled on falling system clock
  logic p_clk = 1'b0, p_le = 1'b0, p_done = 1'b0, p_to = 1'b0;
  int hi_run = 0, lo_run = 0, le_run = 0, gap = 1000;
  int bad_hi = 0, bad_lo = 0, bad_le = 0, bad_gap = 0;
  int le_fall_cyc = 0, end_cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (ser_clk && !p_clk) begin
      if (lo_run < DIV) bad_lo++;
      if (gap < 2 * DIV) bad_gap++;
      hi_run = 0;
    end
    if (!ser_clk && p_clk) begin
      if (hi_run != DIV) bad_hi++;
      lo_run = 0;
    end
    if (ser_le && !p_le) le_run = 0;
    if (!ser_le && p_le) begin
      if (le_run != 2 * DIV) bad_le++;
      gap = 0;
      le_fall_cyc = cyc;
    end
    if ((done && !p_done) || (timed_out && !p_to)) end_cyc = cyc;
    hi_run++; lo_run++; le_run++;
    if (gap < 1000) gap++;
    p_clk = ser_clk; p_le = ser_le; p_done = done; p_to = timed_out;
  end

  // lock-detect pattern: 0 low, 1 high, 2 repeating high-high-low
  int lmode = 0;
  int lph = 0;
  always @(negedge clk) begin
    lph = (lph + 1) % 3;
    case (lmode)
      1: lock_det <= 1'b1;
      2: lock_det <= (lph != 2);
      default: lock_det <= 1'b0;
    endcase
  end

  task automatic run_seq(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c,
                         input int nd, input int lm, input int mode, input bit exp_done,
                         input bit mid_start, input bit chk_delay, input string tag);
    int eff;
    @(negedge clk);
    w_ref = a; w_ctl = b; w_fb = c;
    need = NW'(nd); lim = TW'(lm); lmode = mode;
    le_cnt = 0; rx_bits = 0;
    bad_len = 0; bad_hi = 0; bad_lo = 0; bad_le = 0; bad_gap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0 && timed_out == 1'b0, "R8", {tag, " busy after start"}, busy, 1);
    check(chip_en == 1'b1, "R5", {tag, " chip_en up"}, chip_en, 1);
    if (mid_start) begin
      repeat (100) @(negedge clk);
      w_ref = ~a; w_ctl = ~b; w_fb = ~c;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!(done || timed_out)) @(negedge clk);
    repeat (2) @(negedge clk);
    check(le_cnt == 3, "R1", {tag, " commit count"}, le_cnt, 3);
    check(rx[0] == a, "R1", {tag, " word 1 ref"}, rx[0], a);
    check(rx[1] == b, "R1", {tag, " word 2 ctl"}, rx[1], b);
    check(rx[2] == c, "R1", {tag, " word 3 fb"}, rx[2], c);
    check(bad_len == 0, "R3", {tag, " bits before LE"}, bad_len, 0);
    check(bad_hi == 0 && bad_lo == 0, "R4", {tag, " sclk phase widths"}, bad_hi + bad_lo, 0);
    check(bad_le == 0 && bad_gap == 0, "R3", {tag, " LE pulse and gap"}, bad_le + bad_gap, 0);
    check(ser_clk == 1'b0 && ser_le == 1'b0, "R2", {tag, " serial idle"}, {ser_clk, ser_le}, 0);
    check(busy == 1'b0, "R8", {tag, " busy cleared"}, busy, 0);
    if (exp_done) begin
      check(done == 1'b1 && timed_out == 1'b0, "R6", {tag, " lock result"}, {done, timed_out}, 2);
      eff = (nd == 0) ? 1 : nd;
      if (chk_delay)
        check((end_cyc - le_fall_cyc) >= eff && (end_cyc - le_fall_cyc) <= eff + DIV + 10,
              "R6", {tag, " lock latency"}, end_cyc - le_fall_cyc, eff);
    end else begin
      check(done == 1'b0 && timed_out == 1'b1, "R7", {tag, " timeout result"}, {done, timed_out}, 1);
      if (chk_delay)
        check((end_cyc - le_fall_cyc) >= lm && (end_cyc - le_fall_cyc) <= lm + DIV + 10,
              "R7", {tag, " timeout latency"}, end_cyc - le_fall_cyc, lm);
    end
    repeat (20) @(negedge clk);
    check(done == exp_done && timed_out == !exp_done, "R8", {tag, " flags held"}, {done, timed_out}, {exp_done, !exp_done});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check({ser_clk, ser_data, ser_le, chip_en, busy, done, timed_out} == 7'b0, "R9",
          "outputs in reset", {ser_clk, ser_data, ser_le, chip_en, busy, done, timed_out}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check({ser_clk, ser_data, ser_le, chip_en, busy, done, timed_out} == 7'b0, "R9",
          "outputs after reset", {ser_clk, ser_data, ser_le, chip_en, busy, done, timed_out}, 0);

    run_seq(24'hA5C3_0F, 24'h123456, 24'hFEDCBA, 3, 1000, 1, 1'b1, 1'b0, 1'b1, "basic");
    for (int k = 0; k <= 5; k++)
      run_seq(24'h000001 << (k * 4), 24'hFFFFFF ^ (24'h1 << k), 24'h555555 + 24'(k * 24'h010101),
              k, 2000, 1, 1'b1, 1'b0, 1'b1, "need sweep");
    run_seq(24'hFFFFFF, 24'h000000, 24'hAAAAAA, 2, 200, 0, 1'b0, 1'b0, 1'b1, "no lock");
    run_seq(24'h800001, 24'h7FFFFE, 24'h0F0F0F, 4, 300, 2, 1'b0, 1'b0, 1'b0, "short runs");
    run_seq(24'h3C3C3C, 24'hC3C3C3, 24'h010203, 2, 300, 2, 1'b1, 1'b0, 1'b0, "runs of two");
    run_seq(24'hDEADBE, 24'h0BEEF0, 24'h13579B, 1, 500, 1, 1'b1, 1'b1, 1'b1, "start ignored");
    check(chip_en == 1'b1, "R5", "chip_en stays up when idle", chip_en, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule